// File: doc/BRIEF.md
# Eight-Channel Addressable Output Latch

This block keeps eight on/off channel states. A binary select input picks one channel, a single data bit gives the value to load, and two active-low controls, an enable and a clear, choose one of four operating modes on each rising clock edge. With clear inactive, a low enable writes the data bit into the selected channel and leaves the other channels alone. A high enable holds every channel. With clear active, a high enable turns every channel off. A low enable makes the block act as a demultiplexer: the selected channel takes the data bit and every other channel goes off.

The channel states are available in two forms. One is an active-high "on" vector. The other is an active-low drive vector for external switches, where a 0 turns a load on. Both come from registers and change together. A synchronous reset stands in for a power-on clear and turns every channel off.

Top module: `relay_latch_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is all channels off: `on_vec` = 0 and `drv_n` all ones.
- R2: With `clr_n`=1 and `en_n`=0, channel `sel` takes `din` at the edge. Every other channel keeps its state.
- R3: With `clr_n`=1 and `en_n`=1, no channel changes, whatever `sel` and `din` are.
- R4: With `clr_n`=0 and `en_n`=1, every channel is off after the edge, whatever `sel` and `din` are.
- R5: With `clr_n`=0, `en_n`=0 and `din`=1, only channel `sel` is on after the edge.
- R6: With `clr_n`=0, `en_n`=0 and `din`=0, every channel is off after the edge.
- R7: `drv_n` is always the bitwise inverse of `on_vec`.
- R8: `sel` is an unsigned binary index. Value k addresses bit k of `on_vec` and of `drv_n`.
- R9: Inputs are sampled on a rising edge and the result shows on the outputs right after that same edge. A channel state set by a write stays in place across later writes to other channels and across hold cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, turns all channels off |
| sel | input | ADDR_W (3) | Binary channel select |
| din | input | 1 | Data bit, 1 = on, 0 = off |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| on_vec | output | 2**ADDR_W (8) | Channel states, 1 = on |
| drv_n | output | 2**ADDR_W (8) | Drive outputs, 0 = load on |

## Verification
The hardest case to reach is a mixed pattern of channels that is already latched when a demultiplex cycle or a write with data low arrives. Only that case shows whether unselected channels are kept (write) or wiped (demultiplex). The bench therefore builds alternating and sparse patterns with writes first. It then fires each of the four modes at every address with both data values, checking kept and cleared channels bit by bit against its own model. A long seeded sequence, weighted toward hold cycles, interleaves all modes so that state has to persist between them.

// File: rtl/relay_pkg.sv
package relay_pkg;
  typedef enum logic [1:0] {
    MD_HOLD  = 2'd0,
    MD_WRITE = 2'd1,
    MD_CLEAR = 2'd2,
    MD_DEMUX = 2'd3
  } rl_mode_e;
endpackage

// File: rtl/relay_mode_ctl.sv
module relay_mode_ctl
  import relay_pkg::*;
(
  input  logic     en_n,
  input  logic     clr_n,
  output rl_mode_e mode
);
  // The enable/clear pair chooses one of four modes
  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   mode = MD_WRITE;
      2'b11:   mode = MD_HOLD;
      2'b01:   mode = MD_CLEAR;
      default: mode = MD_DEMUX;
    endcase
  end
endmodule

// File: rtl/relay_sel_dec.sv
module relay_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [N-1:0]      hit
);
  // One-of-N decoder, one compare per channel
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/relay_state_reg.sv
module relay_state_reg
  import relay_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  rl_mode_e     mode,
  input  logic [N-1:0] hit,
  input  logic         din,
  output logic [N-1:0] on_q,
  output logic [N-1:0] drv_q
);
  logic [N-1:0] on_d;

  // Next state per channel
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MD_WRITE: on_d[i] = hit[i] ? din : on_q[i];
        MD_CLEAR: on_d[i] = 1'b0;
        MD_DEMUX: on_d[i] = hit[i] & din;
        default:  on_d[i] = on_q[i];
      endcase
    end
  end

  // The on vector and the inverted drive vector are registered side by side
  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= '0;
      drv_q <= '1;
    end else begin
      on_q  <= on_d;
      drv_q <= ~on_d;
    end
  end

  AST_RESET_OFF: assert property (@(posedge clk) rst |=> (on_q == '0)) else $error("reset"); // R1
  AST_WRITE_HIT: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WRITE) |=> ((on_q & $past(hit)) == ($past(din) ? $past(hit) : '0))) else $error("write"); // R2
  AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WRITE) |=> ((on_q & ~$past(hit)) == ($past(on_q) & ~$past(hit)))) else $error("keep"); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_HOLD) |=> $stable(on_q)) else $error("hold"); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_CLEAR) |=> (on_q == '0)) else $error("clear"); // R4
  AST_DEMUX_ONE: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DEMUX && din) |=> (on_q == $past(hit))) else $error("demux1"); // R5
  AST_DEMUX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DEMUX && !din) |=> (on_q == '0)) else $error("demux0"); // R6
endmodule

// File: rtl/relay_latch_top.sv
module relay_latch_top
  import relay_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [N-1:0]      on_vec,
  output logic [N-1:0]      drv_n
);
  rl_mode_e     mode;
  logic [N-1:0] hit;

  relay_mode_ctl u_ctl (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  relay_sel_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel (sel),
    .hit (hit)
  );

  relay_state_reg #(.N(N)) u_st (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .hit   (hit),
    .din   (din),
    .on_q  (on_vec),
    .drv_q (drv_n)
  );

  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(hit) == 1) else $error("decode"); // R8
  AST_DEC_INDEX: assert property (@(posedge clk) disable iff (rst)
    hit[sel] == 1'b1) else $error("index"); // R8
  AST_POLARITY: assert property (@(posedge clk) disable iff (rst)
    drv_n == ~on_vec) else $error("polarity"); // R7
endmodule

// File: tb/sim_relay_latch_top.sv
module sim_relay_latch_top;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] sel = '0;
  logic          din = 1'b0;
  logic          en_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [N-1:0]  on_vec, drv_n;

  logic [N-1:0]  exp_on = '0;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  relay_latch_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .din(din),
    .en_n(en_n), .clr_n(clr_n), .on_vec(on_vec), .drv_n(drv_n)
  );

  task automatic check(input string req);
    n_chk++;
    if (on_vec !== exp_on || drv_n !== ~exp_on) begin
      n_bad++;
      $display("FAIL %s on_vec=%b drv_n=%b expected on_vec=%b drv_n=%b",
               req, on_vec, drv_n, exp_on, ~exp_on);
    end
  endtask

  // Drive one cycle at the falling edge, update model, sample after rising edge
  task automatic step(input logic c, input logic e, input logic [AW-1:0] a,
                      input logic d, input string req);
    @(negedge clk);
    clr_n = c; en_n = e; sel = a; din = d;
    case ({c, e})
      2'b10: exp_on[a] = d;
      2'b11: ;
      2'b01: exp_on = '0;
      default: exp_on = d ? (N'(1) << a) : '0;
    endcase
    @(posedge clk); #2;
    check(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2; exp_on = '0;
    check("R1 reset all off");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_addr_map;
    for (int k = 0; k < N; k++) begin
      step(1'b0, 1'b1, '0, 1'b0, "R4 clear before map");
      step(1'b1, 1'b0, AW'(k), 1'b1, "R8 index maps to bit");
      if (on_vec[k] !== 1'b1 || drv_n[k] !== 1'b0) begin
        n_bad++;
        $display("FAIL R8 k=%0d on=%b drv=%b expected bit set/low", k, on_vec, drv_n);
      end
      n_chk++;
    end
  endtask

  task automatic t_write_accumulate;
    step(1'b0, 1'b1, '0, 1'b0, "R4 clear");
    for (int k = 0; k < N; k += 2) step(1'b1, 1'b0, AW'(k), 1'b1, "R9 writes accumulate");
    for (int k = 0; k < N; k++) step(1'b1, 1'b1, AW'(k), ~k[0], "R3 hold ignores inputs");
    step(1'b1, 1'b0, 3'd4, 1'b0, "R2 write zero keeps others");
    step(1'b1, 1'b0, 3'd7, 1'b1, "R2 write one keeps others");
  endtask

  task automatic t_all_modes;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < N; k++)
        for (int d = 0; d < 2; d++) begin
          step(1'b1, 1'b0, AW'(k ^ 5), 1'b1, "R2 preload");
          step(1'b1, 1'b0, AW'(k ^ 2), 1'b1, "R2 preload");
          case (m)
            0: step(1'b1, 1'b0, AW'(k), d[0], "R2 write sweep");
            1: step(1'b1, 1'b1, AW'(k), d[0], "R3 hold sweep");
            2: step(1'b0, 1'b1, AW'(k), d[0], "R4 clear sweep");
            default: step(1'b0, 1'b0, AW'(k), d[0], d[0] ? "R5 demux one" : "R6 demux zero");
          endcase
        end
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      step(1'b1, 1'b1, AW'($urandom), 1'($urandom), "R3 mixed hold");
      else if (r < 7) step(1'b1, 1'b0, AW'($urandom), 1'($urandom), "R2 mixed write");
      else if (r < 8) step(1'b0, 1'b1, AW'($urandom), 1'($urandom), "R4 mixed clear");
      else            step(1'b0, 1'b0, AW'($urandom), 1'($urandom), "R5 R6 mixed demux");
      if (drv_n !== ~on_vec) begin
        n_bad++;
        $display("FAIL R7 drv_n=%b expected %b", drv_n, ~on_vec);
      end
      n_chk++;
    end
  endtask

  task automatic t_reset_mid;
    step(1'b1, 1'b0, 3'd3, 1'b1, "R2 set before reset");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2; exp_on = '0;
    check("R1 reset mid-run");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5a17));
    t_reset();
    t_addr_map();
    t_write_accumulate();
    t_all_modes();
    t_mixed();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule